// File: doc/BRIEF.md
# Crossbar Slave-Port Arbiter with Parking

This block sits at one slave port of a multi-master bus crossbar that carries pipelined AHB-Lite style transfers. Each master port presents an address phase (transfer type, address, direction, size) together with a select line that says whether the transfer is aimed at this slave port. The block picks one master to own the port by fixed priority, with lower index winning. It drives that master's address phase onto the slave bus and steers the data phase back to it. Masters that are waiting for the port see their ready held low. A transfer that is accepted while its master is not yet granted is captured locally and replayed when the port is won.

Ownership is sticky. The owner keeps the port for as long as it keeps issuing transfers here. It gives the port up when it goes idle or aims elsewhere and someone else is waiting, or when a higher-priority master asks for the port. A port with no requests stays parked on its last owner, so that master starts again with no arbitration clock. Taking the port for any other master costs one clock, during which the slave bus carries IDLE. The block answers IDLE and BUSY transfers itself and puts IDLE on the slave bus whenever nobody is requesting. It has no software-visible configuration.

Top module: `xbar_slave_port`

## Requirements
- R1: After reset the slave bus carries IDLE (transfer code 2'b00), every master sees ready high with an OKAY response (0), and the port is parked on master 0.
- R2: A NONSEQ (2'b10) or SEQ (2'b11) transfer from the master the port is parked on appears on the slave bus in the same cycle, when no lower-indexed master is requesting. Its data phase completes as soon as the slave is ready.
- R3: A request from a master the port is not parked on costs exactly one arbitration clock, during which the slave bus carries IDLE. The transfer appears on the slave bus the next cycle, and the master's ready stays low until its data phase completes.
- R4: An owner that keeps issuing transfers keeps the port against lower-indexed-priority (higher index) requesters, which wait with ready low.
- R5: A request from a higher-priority (lower index) master takes the port from the owner at the next transfer boundary.
- R6: IDLE (2'b00) or BUSY (2'b01) transfers, and transfers with the select low, get a zero-wait OKAY response and are never put on the slave bus.
- R7: When no master is requesting and none is waiting, the slave bus carries IDLE.
- R8: A port with no requests stays parked on its last owner, so a new request from that master goes out in the same cycle.
- R9: The owner changes only in a cycle where the slave's ready is high. Slave wait states reach the master whose data phase is in progress.
- R10: Write data to the slave comes from the master whose address phase went out in the previous accepted cycle. That master alone receives the slave's ready and response. Every master receives the slave's read data.
- R11: A SEQ transfer goes out as NONSEQ unless the previous accepted address phase on the slave bus was a transfer from the same master.
- R12: A transfer captured while its master waits goes out with the address, direction and size sampled when it was accepted, even after that master's bus has moved on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_sel | input | NM | Per master: transfer is aimed at this slave port |
| m_htrans | input | NM x 2 | Per master transfer type |
| m_haddr | input | NM x 32 | Per master address |
| m_hwrite | input | NM | Per master direction, 1 = write |
| m_hsize | input | NM x 3 | Per master transfer size |
| m_hwdata | input | NM x 32 | Per master write data (data phase) |
| m_hready | output | NM | Per master ready, ends the master's data phase |
| m_hresp | output | NM | Per master response, 1 = error |
| m_hrdata | output | 32 | Read data to all masters |
| s_htrans | output | 2 | Transfer type on the slave bus |
| s_haddr | output | 32 | Address on the slave bus |
| s_hwrite | output | 1 | Direction on the slave bus |
| s_hsize | output | 3 | Size on the slave bus |
| s_hwdata | output | 32 | Write data on the slave bus |
| s_hreadyout | input | 1 | Slave ready |
| s_hresp | input | 1 | Slave response |
| s_hrdata | input | 32 | Slave read data |

## Verification
The hardest case to reach is a preemption that arrives while the owner's data phase is stretched by slave wait states. In that case the owner has already presented its next address, which must be captured rather than lost. The port must not change hands until the slave releases ready, and both displaced transfers must come out later, in priority order. The preemption scenario holds the slave's ready low for one cycle while master 0 raises a request against the streaming master 3. It then releases ready and follows both captured transfers onto the slave bus across two arbitration clocks.

// File: rtl/xsp_pkg.sv
package xsp_pkg;

    parameter int unsigned XSP_ADDR_W = 32;
    parameter int unsigned XSP_DATA_W = 32;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    // address-phase bundle carried from a master side to the slave bus
    typedef struct packed {
        logic [XSP_ADDR_W-1:0] addr;
        logic                  write;
        logic [2:0]            size;
        trans_e                trans;
    } aphase_t;

    // where a master's current data phase is being serviced
    typedef enum logic [1:0] {
        MS_LOCAL = 2'd0,   // answered by the port itself, zero wait
        MS_PEND  = 2'd1,   // accepted, captured, waiting for the port
        MS_SLAVE = 2'd2    // forwarded, slave data phase in flight
    } mstate_e;

    localparam aphase_t APH_IDLE = '{addr: '0, write: 1'b0, size: 3'b000, trans: TR_IDLE};

    function automatic logic is_xfer(input logic sel, input logic [1:0] tr);
        return sel & tr[1];
    endfunction

endpackage

// File: rtl/xsp_master_side.sv
module xsp_master_side
    import xsp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sel,
    input  logic [1:0]            htrans,
    input  logic [XSP_ADDR_W-1:0] haddr,
    input  logic                  hwrite,
    input  logic [2:0]            hsize,
    input  logic                  s_ready,
    input  logic                  s_resp,
    input  logic                  fwd_me,
    output logic                  req,
    output aphase_t               req_aph,
    output logic                  hready,
    output logic                  hresp,
    output logic                  in_pend,
    output logic                  in_slave
);

    mstate_e st_q, st_d;
    aphase_t hold_q;
    aphase_t live;
    logic    live_req;

    assign live     = '{addr: haddr, write: hwrite, size: hsize, trans: trans_e'(htrans)};
    assign live_req = is_xfer(sel, htrans);

    assign in_pend  = (st_q == MS_PEND);
    assign in_slave = (st_q == MS_SLAVE);

    always_comb begin
        unique case (st_q)
            MS_PEND:  hready = 1'b0;
            MS_SLAVE: hready = s_ready;
            default:  hready = 1'b1;
        endcase
    end

    assign hresp   = in_slave & s_resp;
    assign req     = in_pend | live_req;
    assign req_aph = in_pend ? hold_q : live;

    always_comb begin
        st_d = st_q;
        if (in_pend) begin
            if (fwd_me) st_d = MS_SLAVE;
        end else if (hready) begin
            if (live_req) st_d = fwd_me ? MS_SLAVE : MS_PEND;
            else          st_d = MS_LOCAL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= MS_LOCAL;
            hold_q <= APH_IDLE;
        end else begin
            st_q <= st_d;
            if (!in_pend && hready && live_req && !fwd_me) hold_q <= live;
        end
    end

endmodule

// File: rtl/xsp_arbiter.sv
module xsp_arbiter #(
    parameter int unsigned NM = 4,
    localparam int unsigned IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NM-1:0] req,
    input  logic          s_ready,
    output logic [IW-1:0] own,
    output logic          show,
    output logic          fwd
);

    logic [IW-1:0] own_q;
    logic [IW-1:0] top;
    logic          any;

    always_comb begin
        any = |req;
        top = '0;
        for (int i = NM - 1; i >= 0; i--) begin
            if (req[i]) top = IW'(i);
        end
    end

    assign own  = own_q;
    assign show = any && (top == own_q);
    assign fwd  = show && s_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= '0;
        end else if (s_ready && any && (top != own_q)) begin
            own_q <= top;
        end
    end

endmodule

// File: rtl/xsp_slave_drive.sv
module xsp_slave_drive
    import xsp_pkg::*;
#(
    parameter int unsigned NM = 4,
    localparam int unsigned IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  aphase_t                        cand,
    input  logic                           show,
    input  logic                           fwd,
    input  logic [IW-1:0]                  own,
    input  logic                           s_ready,
    input  logic [NM-1:0][XSP_DATA_W-1:0]  m_hwdata,
    output logic [1:0]                     s_htrans,
    output logic [XSP_ADDR_W-1:0]          s_haddr,
    output logic                           s_hwrite,
    output logic [2:0]                     s_hsize,
    output logic [XSP_DATA_W-1:0]          s_hwdata
);

    logic          dp_act_q;
    logic [IW-1:0] dp_own_q;
    logic          seq_ok;
    trans_e        tr_out;

    assign seq_ok = dp_act_q && (dp_own_q == own);

    always_comb begin
        if (!show)                                  tr_out = TR_IDLE;
        else if (cand.trans == TR_SEQ && !seq_ok)   tr_out = TR_NONSEQ;
        else                                        tr_out = cand.trans;
    end

    assign s_htrans = tr_out;
    assign s_haddr  = cand.addr;
    assign s_hwrite = show & cand.write;
    assign s_hsize  = cand.size;
    assign s_hwdata = m_hwdata[dp_own_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_act_q <= 1'b0;
            dp_own_q <= '0;
        end else if (s_ready) begin
            dp_act_q <= fwd;
            if (fwd) dp_own_q <= own;
        end
    end

endmodule

// File: rtl/xbar_slave_port.sv
module xbar_slave_port
    import xsp_pkg::*;
#(
    parameter int unsigned NM = 4,
    localparam int unsigned IW = (NM > 1) ? $clog2(NM) : 1,
    localparam int unsigned AW = XSP_ADDR_W,
    localparam int unsigned DW = XSP_DATA_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NM-1:0]          m_sel,
    input  logic [NM-1:0][1:0]     m_htrans,
    input  logic [NM-1:0][AW-1:0]  m_haddr,
    input  logic [NM-1:0]          m_hwrite,
    input  logic [NM-1:0][2:0]     m_hsize,
    input  logic [NM-1:0][DW-1:0]  m_hwdata,
    output logic [NM-1:0]          m_hready,
    output logic [NM-1:0]          m_hresp,
    output logic [DW-1:0]          m_hrdata,
    output logic [1:0]             s_htrans,
    output logic [AW-1:0]          s_haddr,
    output logic                   s_hwrite,
    output logic [2:0]             s_hsize,
    output logic [DW-1:0]          s_hwdata,
    input  logic                   s_hreadyout,
    input  logic                   s_hresp,
    input  logic [DW-1:0]          s_hrdata
);

    logic [NM-1:0] req;
    logic [NM-1:0] fwd_me;
    logic [NM-1:0] pend_vec;
    logic [NM-1:0] slv_vec;
    aphase_t       req_aph [NM];
    aphase_t       cand;
    logic [IW-1:0] park_id;
    logic          show;
    logic          fwd;

    for (genvar g = 0; g < NM; g++) begin : g_mst
        assign fwd_me[g] = fwd && (park_id == IW'(g));

        xsp_master_side u_side (
            .clk      (clk),
            .rst      (rst),
            .sel      (m_sel[g]),
            .htrans   (m_htrans[g]),
            .haddr    (m_haddr[g]),
            .hwrite   (m_hwrite[g]),
            .hsize    (m_hsize[g]),
            .s_ready  (s_hreadyout),
            .s_resp   (s_hresp),
            .fwd_me   (fwd_me[g]),
            .req      (req[g]),
            .req_aph  (req_aph[g]),
            .hready   (m_hready[g]),
            .hresp    (m_hresp[g]),
            .in_pend  (pend_vec[g]),
            .in_slave (slv_vec[g])
        );
    end

    xsp_arbiter #(.NM(NM)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .s_ready (s_hreadyout),
        .own     (park_id),
        .show    (show),
        .fwd     (fwd)
    );

    assign cand = req_aph[park_id];

    xsp_slave_drive #(.NM(NM)) u_drv (
        .clk      (clk),
        .rst      (rst),
        .cand     (cand),
        .show     (show),
        .fwd      (fwd),
        .own      (park_id),
        .s_ready  (s_hreadyout),
        .m_hwdata (m_hwdata),
        .s_htrans (s_htrans),
        .s_haddr  (s_haddr),
        .s_hwrite (s_hwrite),
        .s_hsize  (s_hsize),
        .s_hwdata (s_hwdata)
    );

    assign m_hrdata = s_hrdata;

endmodule

// File: rtl/xbar_slave_port_chk.sv
module xbar_slave_port_chk #(
    parameter int unsigned NM = 4,
    localparam int unsigned IW = (NM > 1) ? $clog2(NM) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic [NM-1:0]      m_sel,
    input logic [NM-1:0][1:0] m_htrans,
    input logic [NM-1:0]      m_hready,
    input logic [NM-1:0]      m_hresp,
    input logic [1:0]         s_htrans,
    input logic               s_hreadyout,
    input logic [IW-1:0]      park_id,
    input logic [NM-1:0]      pend_vec,
    input logic [NM-1:0]      slv_vec
);

    logic [NM-1:0] asks;

    always_comb begin
        for (int i = 0; i < NM; i++) asks[i] = m_sel[i] & m_htrans[i][1];
    end

    // R9: owner frozen while the slave stretches a data phase
    assert_park_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !s_hreadyout |=> $stable(park_id));

    // R10: at most one master is in a slave data phase
    assert_one_dp_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slv_vec));

    // R7: quiet masters give a quiet slave bus
    assert_quiet_bus_R7: assert property (@(posedge clk) disable iff (rst)
        (asks == '0 && pend_vec == '0) |-> s_htrans == 2'b00);

    // R11: SEQ only continues the same master's stream
    assert_seq_cont_R11: assert property (@(posedge clk) disable iff (rst)
        (s_htrans == 2'b11) |-> slv_vec[park_id]);

    // R2: top-priority parked master goes out in the same cycle
    assert_zero_wait_R2: assert property (@(posedge clk) disable iff (rst)
        (asks[0] && park_id == '0 && pend_vec == '0) |-> s_htrans[1]);

    for (genvar g = 0; g < NM; g++) begin : g_m
        // R6: a sampled non-request is answered locally with zero wait OKAY
        assert_local_ok_R6: assert property (@(posedge clk) disable iff (rst)
            (m_hready[g] && !asks[g]) |=> (m_hready[g] && !m_hresp[g]));

        // R3: a sampled request to a port parked elsewhere is held
        assert_arb_wait_R3: assert property (@(posedge clk) disable iff (rst)
            (m_hready[g] && asks[g] && park_id != IW'(g)) |=> !m_hready[g]);
    end

endmodule

bind xbar_slave_port xbar_slave_port_chk #(.NM(NM)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .m_sel       (m_sel),
    .m_htrans    (m_htrans),
    .m_hready    (m_hready),
    .m_hresp     (m_hresp),
    .s_htrans    (s_htrans),
    .s_hreadyout (s_hreadyout),
    .park_id     (park_id),
    .pend_vec    (pend_vec),
    .slv_vec     (slv_vec)
);

// File: tb/xbar_slave_port_tb.sv
`timescale 1ns/1ps
module xbar_slave_port_tb;
    import xsp_pkg::*;

    localparam int NM = 4;
    localparam int AW = XSP_ADDR_W;
    localparam int DW = XSP_DATA_W;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NM-1:0]         m_sel = '0;
    logic [NM-1:0][1:0]    m_htrans = '0;
    logic [NM-1:0][AW-1:0] m_haddr = '0;
    logic [NM-1:0]         m_hwrite = '0;
    logic [NM-1:0][2:0]    m_hsize = '0;
    logic [NM-1:0][DW-1:0] m_hwdata = '0;
    logic [NM-1:0]         m_hready;
    logic [NM-1:0]         m_hresp;
    logic [DW-1:0]         m_hrdata;
    logic [1:0]            s_htrans;
    logic [AW-1:0]         s_haddr;
    logic                  s_hwrite;
    logic [2:0]            s_hsize;
    logic [DW-1:0]         s_hwdata;
    logic                  s_hreadyout = 1'b1;
    logic                  s_hresp = 1'b0;
    logic [DW-1:0]         s_hrdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    xbar_slave_port #(.NM(NM)) u_dut (.*);

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic settle;
        #1;
    endtask

    task automatic drv(input int i, input logic sel, input logic [1:0] tr,
                       input logic [AW-1:0] a, input logic w, input logic [DW-1:0] wd);
        m_sel[i]    = sel;
        m_htrans[i] = tr;
        m_haddr[i]  = a;
        m_hwrite[i] = w;
        m_hsize[i]  = 3'd2;
        m_hwdata[i] = wd;
    endtask

    task automatic quiet(input int i);
        m_sel[i]    = 1'b0;
        m_htrans[i] = 2'b00;
    endtask

    task automatic t_reset;
        settle;
        chk("R1", "slave bus idle", 64'(s_htrans), 64'(2'b00));
        chk("R1", "all ready", 64'(m_hready), 64'(4'hF));
        chk("R1", "all okay", 64'(m_hresp), 64'(4'h0));
    endtask

    task automatic t_zero_wait;   // parked on 0 from reset
        tick; drv(0, 1, 2'b10, 32'h0000_1000, 1, 32'hA0A0_0001); settle;
        chk("R1", "master0 parked, same-cycle type", 64'(s_htrans), 64'(2'b10));
        chk("R2", "same-cycle address", 64'(s_haddr), 64'h1000);
        tick; quiet(0); settle;
        chk("R2", "zero-wait ready", 64'(m_hready[0]), 64'd1);
        chk("R10", "write data from owner", 64'(s_hwdata), 64'hA0A0_0001);
        chk("R7", "bus idle without requests", 64'(s_htrans), 64'(2'b00));
    endtask

    task automatic t_arb_clock;   // parked on 0, master 2 asks
        tick; drv(2, 1, 2'b10, 32'h0000_2200, 1, 32'h2222_0002); settle;
        chk("R3", "arbitration clock idle", 64'(s_htrans), 64'(2'b00));
        tick; quiet(2); settle;
        chk("R3", "transfer one clock later", 64'(s_htrans), 64'(2'b10));
        chk("R12", "captured address", 64'(s_haddr), 64'h2200);
        chk("R12", "captured direction", 64'(s_hwrite), 64'd1);
        chk("R3", "waiting ready low", 64'(m_hready[2]), 64'd0);
        tick; settle;
        chk("R3", "data phase done", 64'(m_hready[2]), 64'd1);
        chk("R10", "write data master2", 64'(s_hwdata), 64'h2222_0002);
    endtask

    task automatic t_park;        // parked on 2
        tick; tick; drv(2, 1, 2'b10, 32'h0000_3300, 0, 32'h0); settle;
        chk("R8", "parked master same cycle", 64'(s_htrans), 64'(2'b10));
        chk("R8", "parked master address", 64'(s_haddr), 64'h3300);
        tick; quiet(2); settle;
        chk("R8", "parked master ready", 64'(m_hready[2]), 64'd1);
    endtask

    task automatic t_hold;        // owner 2 streams, 3 waits
        tick;
        drv(2, 1, 2'b10, 32'h0000_4000, 1, 32'hB0B0_0000);
        drv(3, 1, 2'b10, 32'h0000_5000, 1, 32'hC3C3_0003);
        settle;
        chk("R4", "owner first beat", 64'(s_haddr), 64'h4000);
        tick; drv(2, 1, 2'b11, 32'h0000_4004, 1, 32'hB0B0_0000); quiet(3); settle;
        chk("R11", "continued SEQ kept", 64'(s_htrans), 64'(2'b11));
        chk("R4", "owner second beat", 64'(s_haddr), 64'h4004);
        chk("R4", "lower priority waits", 64'(m_hready[3]), 64'd0);
        tick; quiet(2); m_hwdata[2] = 32'hB0B0_0001; settle;
        chk("R3", "switch clock idle", 64'(s_htrans), 64'(2'b00));
        chk("R4", "still waiting", 64'(m_hready[3]), 64'd0);
        chk("R10", "second beat data", 64'(s_hwdata), 64'hB0B0_0001);
        tick; settle;
        chk("R12", "waiting transfer out", 64'(s_haddr), 64'h5000);
        chk("R3", "waiting transfer type", 64'(s_htrans), 64'(2'b10));
        tick; settle;
        chk("R3", "master3 done", 64'(m_hready[3]), 64'd1);
        chk("R10", "master3 data", 64'(s_hwdata), 64'hC3C3_0003);
    endtask

    task automatic t_preempt;     // parked on 3
        tick; drv(3, 1, 2'b10, 32'h0000_6000, 1, 32'hD0D0_0000); settle;
        chk("R8", "owner3 zero wait", 64'(s_haddr), 64'h6000);
        tick;
        drv(3, 1, 2'b10, 32'h0000_6100, 1, 32'hD0D0_0000);
        drv(0, 1, 2'b10, 32'h0000_7000, 0, 32'h0);
        s_hreadyout = 1'b0;
        settle;
        chk("R9", "wait state to owner", 64'(m_hready[3]), 64'd0);
        chk("R9", "no switch mid data phase", 64'(s_htrans), 64'(2'b00));
        chk("R10", "held write data", 64'(s_hwdata), 64'hD0D0_0000);
        tick; s_hreadyout = 1'b1; settle;
        chk("R9", "owner data phase ends", 64'(m_hready[3]), 64'd1);
        chk("R5", "preemptor waits", 64'(m_hready[0]), 64'd0);
        chk("R5", "arbitration clock", 64'(s_htrans), 64'(2'b00));
        tick; quiet(3); m_hwdata[3] = 32'hD0D0_0001; settle;
        chk("R5", "preemptor address", 64'(s_haddr), 64'h7000);
        chk("R5", "preemptor type", 64'(s_htrans), 64'(2'b10));
        chk("R5", "displaced owner waits", 64'(m_hready[3]), 64'd0);
        tick; quiet(0); settle;
        chk("R5", "preemptor done", 64'(m_hready[0]), 64'd1);
        chk("R3", "switch back clock", 64'(s_htrans), 64'(2'b00));
        tick; settle;
        chk("R12", "displaced transfer", 64'(s_haddr), 64'h6100);
        tick; settle;
        chk("R10", "displaced data", 64'(s_hwdata), 64'hD0D0_0001);
        chk("R9", "displaced done", 64'(m_hready[3]), 64'd1);
    endtask

    task automatic t_idle_local;  // parked on 3
        tick;
        drv(0, 1, 2'b00, 32'h0000_8000, 0, 32'h0);
        drv(1, 0, 2'b10, 32'h0000_8100, 0, 32'h0);
        drv(2, 1, 2'b01, 32'h0000_8200, 0, 32'h0);
        settle;
        chk("R6", "nothing forwarded", 64'(s_htrans), 64'(2'b00));
        tick; settle;
        chk("R6", "local ready", 64'(m_hready[2:0]), 64'(3'b111));
        chk("R6", "local okay", 64'(m_hresp[2:0]), 64'(3'b000));
        chk("R6", "still nothing forwarded", 64'(s_htrans), 64'(2'b00));
        quiet(0); quiet(1); quiet(2);
    endtask

    task automatic t_resp;        // parked on 3, read with error
        tick; drv(3, 1, 2'b10, 32'h0000_9000, 0, 32'h0); settle;
        chk("R8", "park kept after idles", 64'(s_haddr), 64'h9000);
        tick; quiet(3); s_hreadyout = 1'b0; s_hresp = 1'b1; s_hrdata = 32'h1234_5678; settle;
        chk("R10", "response to owner", 64'(m_hresp[3]), 64'd1);
        chk("R10", "wait to owner", 64'(m_hready[3]), 64'd0);
        chk("R10", "others okay", 64'(m_hresp[0]), 64'd0);
        chk("R10", "others ready", 64'(m_hready[0]), 64'd1);
        tick; s_hreadyout = 1'b1; settle;
        chk("R10", "owner done", 64'(m_hready[3]), 64'd1);
        chk("R10", "read data", 64'(m_hrdata), 64'h1234_5678);
        tick; s_hresp = 1'b0; settle;
        chk("R10", "response cleared", 64'(m_hresp[3]), 64'd0);
    endtask

    task automatic t_seq_fix;     // parked on 3, master 1 starts with SEQ
        tick; drv(1, 1, 2'b11, 32'h0000_A000, 1, 32'hE1E1_0001); settle;
        chk("R3", "arbitration clock", 64'(s_htrans), 64'(2'b00));
        tick; quiet(1); settle;
        chk("R11", "SEQ becomes NONSEQ", 64'(s_htrans), 64'(2'b10));
        chk("R12", "address", 64'(s_haddr), 64'hA000);
        tick; settle;
        chk("R11", "done", 64'(m_hready[1]), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_zero_wait;
        t_arb_clock;
        t_park;
        t_hold;
        t_preempt;
        t_idle_local;
        t_resp;
        t_seq_fix;
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule